// File: doc/BRIEF.md
# Error-Filtering Receive Ring Buffer

This block sits between a serial receiver and the logic that consumes its bytes. Every received byte comes with four line flags: overrun, parity error, framing error and break. Only bytes with no flag set are written into a circular store. Flagged bytes are thrown away, and each of the three error kinds is tallied in its own saturating counter.

The store has one more slot than its nominal capacity DEPTH. It counts as full when the next write slot would land on the read slot. A consumer asks for up to K bytes with a single-cycle request. The block streams min(K, occupancy) bytes, one per cycle, and then pulses a done strobe that carries the number returned. A one-cycle notify pulse marks the end of each receive burst, so the consumer knows when to come and drain.

Top module: `err_filter_ring`

## Requirements
- R1: A byte that arrives with any of overrun, parity, framing or break set is never written into the store and never appears on the read stream.
- R2: Overrun, parity and framing each increment their own counter by one per flagged byte. A byte carrying several of these flags increments every matching counter in the same cycle.
- R3: A byte flagged with break and no other flag is discarded and changes no counter.
- R4: The store holds at most DEPTH bytes (DEPTH+1 slots, full when the write slot is one position behind the read slot). A clean byte that arrives while the store is full is dropped without any other effect.
- R5: A read request for K bytes, sampled in a cycle when no read is in progress, returns exactly min(K, occupancy) bytes. They come one per cycle with out_valid high, starting two cycles after the request edge. A one-cycle rd_done follows, with rd_done_count equal to the number returned. K = 0 or an empty store gives rd_done with count 0 and no data.
- R6: Bytes come out in arrival order. Both indices wrap from slot DEPTH back to slot 0, so order holds across any number of wraps.
- R7: Each error counter is CW bits wide and stays at its all-ones value once it gets there.
- R8: A one-cycle clr_counts strobe sets all three counters to zero at the next edge. A clear takes priority over an increment in the same cycle.
- R9: notify is high for exactly one cycle, in the cycle after the first edge at which in_valid is sampled low following one or more cycles with in_valid high.
- R10: After reset the counters are zero, out_valid, rd_done and notify are low, and the store is empty.
- R11: A read request that arrives while a read is in progress is ignored. It does not change the count or the data of the read in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present this cycle |
| in_data | input | DW | Received byte |
| in_overrun | input | 1 | Overrun flag for this byte |
| in_parity | input | 1 | Parity error flag for this byte |
| in_framing | input | 1 | Framing error flag for this byte |
| in_break | input | 1 | Break flag for this byte |
| clr_counts | input | 1 | Clear all error counters |
| rd_req | input | 1 | Read request strobe |
| rd_count | input | KW | Number of bytes asked for |
| out_valid | output | 1 | Read stream byte valid |
| out_data | output | DW | Read stream byte |
| rd_done | output | 1 | Read finished (one cycle) |
| rd_done_count | output | KW | Bytes returned by the finished read |
| ovr_count | output | CW | Overrun error counter |
| par_count | output | CW | Parity error counter |
| frm_count | output | CW | Framing error counter |
| notify | output | 1 | End-of-burst pulse |

## Verification
A write index that skips or repeats shows up on the very next drain. Bytes come out missing, doubled or out of order, and that is visible within the burst of out_valid that follows the request. A wrong full decision shows as a read that returns DEPTH+1 bytes, or fewer than DEPTH, after an overfill. A miscounted grant is exposed by rd_done_count disagreeing with the number of out_valid beats. Counter faults (a shared increment, a break being counted, a wrap past all-ones) are visible on the counter ports the cycle after the flagged byte. The sweep exercises every flag combination and every fill level from empty to overfull, so each of these faults surfaces within a few cycles.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } line_flags_t;

  // advance a ring index, wrapping after the last slot
  function automatic int unsigned ring_step(int unsigned idx, int unsigned slots);
    return (idx == slots - 1) ? 0 : idx + 1;
  endfunction

  // bytes held between read and write index
  function automatic int unsigned ring_occ(int unsigned wr, int unsigned rd,
                                           int unsigned slots);
    return (rd <= wr) ? (wr - rd) : (wr + slots - rd);
  endfunction

  function automatic int unsigned take_min(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/rx_byte_filter.sv
module rx_byte_filter (
  input  logic valid,
  input  logic ovr,
  input  logic par,
  input  logic frm,
  input  logic brk,
  output logic keep,
  output logic hit_ovr,
  output logic hit_par,
  output logic hit_frm
);
  rxring_pkg::line_flags_t flags;

  assign flags   = '{brk: brk, frm: frm, par: par, ovr: ovr};
  assign keep    = valid && (flags == '0);
  assign hit_ovr = valid && flags.ovr;
  assign hit_par = valid && flags.par;
  assign hit_frm = valid && flags.frm;
endmodule

// File: rtl/sat_err_counter.sv
module sat_err_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   count <= '0;
    else if (clr)                 count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/burst_notify.sv
module burst_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic notify
);
  logic prev_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      notify     <= 1'b0;
    end else begin
      prev_valid <= in_valid;
      notify     <= prev_valid && !in_valid;
    end
  end
endmodule

// File: rtl/rx_ring_store.sv
module rx_ring_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  parameter int KW    = 10,
  parameter int IW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_keep,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic [KW-1:0] rd_count,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          rd_done,
  output logic [KW-1:0] rd_done_count,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic [IW-1:0] occ,
  output logic          busy,
  output logic          full
);
  import rxring_pkg::*;
  localparam int SLOTS = DEPTH + 1;

  logic [DW-1:0] mem [SLOTS];
  logic [KW-1:0] remain;
  logic [KW-1:0] grant;
  logic          do_write;

  assign occ      = IW'(ring_occ(32'(wr_idx), 32'(rd_idx), SLOTS));
  assign full     = (occ == IW'(DEPTH));
  assign do_write = wr_keep && !full;
  assign grant    = KW'(take_min(32'(rd_count), 32'(occ)));

  always_ff @(posedge clk) begin
    if (do_write) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        wr_idx <= '0;
    else if (do_write) wr_idx <= IW'(ring_step(32'(wr_idx), SLOTS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      remain        <= '0;
      rd_idx        <= '0;
      out_valid     <= 1'b0;
      out_data      <= '0;
      rd_done       <= 1'b0;
      rd_done_count <= '0;
    end else begin
      out_valid <= 1'b0;
      rd_done   <= 1'b0;
      if (!busy) begin
        if (rd_req) begin
          busy          <= 1'b1;
          remain        <= grant;
          rd_done_count <= grant;
        end
      end else if (remain != '0) begin
        out_valid <= 1'b1;
        out_data  <= mem[rd_idx];
        rd_idx    <= IW'(ring_step(32'(rd_idx), SLOTS));
        remain    <= remain - 1'b1;
      end else begin
        rd_done <= 1'b1;
        busy    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/err_filter_ring.sv
module err_filter_ring #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  parameter int CW    = 32,
  parameter int KW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_overrun,
  input  logic          in_parity,
  input  logic          in_framing,
  input  logic          in_break,
  input  logic          clr_counts,
  input  logic          rd_req,
  input  logic [KW-1:0] rd_count,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          rd_done,
  output logic [KW-1:0] rd_done_count,
  output logic [CW-1:0] ovr_count,
  output logic [CW-1:0] par_count,
  output logic [CW-1:0] frm_count,
  output logic          notify
);
  localparam int SLOTS = DEPTH + 1;
  localparam int IW    = $clog2(SLOTS);
  localparam int NERR  = 3;

  // named internal events, visible to the bound checker
  logic          keep_byte;
  logic          hit_ovr;
  logic          hit_par;
  logic          hit_frm;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic [IW-1:0] occ;
  logic          rd_busy;
  logic          ring_full;

  logic [NERR-1:0] inc_vec;
  logic [CW-1:0]   cnt_q [NERR];

  rx_byte_filter u_filter (
    .valid   (in_valid),
    .ovr     (in_overrun),
    .par     (in_parity),
    .frm     (in_framing),
    .brk     (in_break),
    .keep    (keep_byte),
    .hit_ovr (hit_ovr),
    .hit_par (hit_par),
    .hit_frm (hit_frm)
  );

  assign inc_vec = {hit_frm, hit_par, hit_ovr};

  for (genvar g = 0; g < NERR; g++) begin : g_cnt
    sat_err_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_counts),
      .inc   (inc_vec[g]),
      .count (cnt_q[g])
    );
  end

  assign ovr_count = cnt_q[0];
  assign par_count = cnt_q[1];
  assign frm_count = cnt_q[2];

  rx_ring_store #(.DEPTH(DEPTH), .DW(DW), .KW(KW), .IW(IW)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_keep       (keep_byte),
    .wr_data       (in_data),
    .rd_req        (rd_req),
    .rd_count      (rd_count),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .rd_done       (rd_done),
    .rd_done_count (rd_done_count),
    .wr_idx        (wr_idx),
    .rd_idx        (rd_idx),
    .occ           (occ),
    .busy          (rd_busy),
    .full          (ring_full)
  );

  burst_notify u_notify (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .notify   (notify)
  );
endmodule

// File: rtl/err_ring_checker.sv
module err_ring_checker #(
  parameter int DEPTH = 512,
  parameter int CW    = 32,
  parameter int IW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_overrun,
  input logic          in_parity,
  input logic          in_framing,
  input logic          in_break,
  input logic          clr_counts,
  input logic          out_valid,
  input logic          rd_done,
  input logic          notify,
  input logic [CW-1:0] ovr_count,
  input logic [CW-1:0] par_count,
  input logic [CW-1:0] frm_count,
  input logic [IW-1:0] wr_idx,
  input logic [IW-1:0] occ,
  input logic          rd_busy
);
  localparam logic [CW-1:0] TOP = '1;

  AST_ERR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_overrun || in_parity || in_framing || in_break)) |=> $stable(wr_idx)); // R1

  AST_MULTI_FLAG_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_overrun && in_parity && !clr_counts && ovr_count != TOP && par_count != TOP)
      |=> (ovr_count == $past(ovr_count) + 1'b1) && (par_count == $past(par_count) + 1'b1)); // R2

  AST_BREAK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_break && !in_overrun && !in_parity && !in_framing && !clr_counts)
      |=> $stable(ovr_count) && $stable(par_count) && $stable(frm_count)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= IW'(DEPTH)); // R4

  AST_STREAM_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rd_busy)); // R5

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !rd_busy && !out_valid); // R5

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_count == TOP && !clr_counts) |=> frm_count == TOP); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_counts |=> (ovr_count == '0) && (par_count == '0) && (frm_count == '0)); // R8

  AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    notify |=> !notify); // R9

  AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> !$past(in_valid) && $past(in_valid, 2)); // R9
endmodule

bind err_filter_ring err_ring_checker #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_overrun (in_overrun),
  .in_parity  (in_parity),
  .in_framing (in_framing),
  .in_break   (in_break),
  .clr_counts (clr_counts),
  .out_valid  (out_valid),
  .rd_done    (rd_done),
  .notify     (notify),
  .ovr_count  (ovr_count),
  .par_count  (par_count),
  .frm_count  (frm_count),
  .wr_idx     (wr_idx),
  .occ        (occ),
  .rd_busy    (rd_busy)
);

// File: tb/err_filter_ring_bench.sv
`timescale 1ns/1ps
module err_filter_ring_bench;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int CW    = 3;
  localparam int KW    = 4;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_overrun = 1'b0;
  logic          in_parity = 1'b0;
  logic          in_framing = 1'b0;
  logic          in_break = 1'b0;
  logic          clr_counts = 1'b0;
  logic          rd_req = 1'b0;
  logic [KW-1:0] rd_count = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          rd_done;
  logic [KW-1:0] rd_done_count;
  logic [CW-1:0] ovr_count;
  logic [CW-1:0] par_count;
  logic [CW-1:0] frm_count;
  logic          notify;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model_q [$];
  int m_ovr = 0, m_par = 0, m_frm = 0;

  always #5 clk = ~clk;

  err_filter_ring #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .KW(KW)) u_err_filter_ring (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_overrun(in_overrun), .in_parity(in_parity), .in_framing(in_framing),
    .in_break(in_break), .clr_counts(clr_counts), .rd_req(rd_req),
    .rd_count(rd_count), .out_valid(out_valid), .out_data(out_data),
    .rd_done(rd_done), .rd_done_count(rd_done_count), .ovr_count(ovr_count),
    .par_count(par_count), .frm_count(frm_count), .notify(notify)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat_add(int v);
    return (v == CMAX) ? CMAX : v + 1;
  endfunction

  // fl: bit0 overrun, bit1 parity, bit2 framing, bit3 break
  task automatic send(input logic [DW-1:0] d, input logic [3:0] fl);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    {in_break, in_framing, in_parity, in_overrun} = fl;
    if (fl == 4'd0 && model_q.size() < DEPTH) model_q.push_back(d);
    if (fl[0]) m_ovr = sat_add(m_ovr);
    if (fl[1]) m_par = sat_add(m_par);
    if (fl[2]) m_frm = sat_add(m_frm);
  endtask

  task automatic end_burst();
    @(negedge clk);
    in_valid = 1'b0;
    {in_break, in_framing, in_parity, in_overrun} = 4'd0;
    @(negedge clk);
    chk(notify == 1'b1, "R9 notify after burst", int'(notify), 1);
    @(negedge clk);
    chk(notify == 1'b0, "R9 notify one cycle", int'(notify), 0);
  endtask

  task automatic check_counts(input string tag);
    chk(int'(ovr_count) == m_ovr, {tag, " overrun count"}, int'(ovr_count), m_ovr);
    chk(int'(par_count) == m_par, {tag, " parity count"}, int'(par_count), m_par);
    chk(int'(frm_count) == m_frm, {tag, " framing count"}, int'(frm_count), m_frm);
  endtask

  task automatic clear_counts();
    @(negedge clk);
    clr_counts = 1'b1;
    @(negedge clk);
    clr_counts = 1'b0;
    m_ovr = 0; m_par = 0; m_frm = 0;
    check_counts("R8 after clear");
  endtask

  task automatic do_read(input int k, input bit poke, input string tag);
    int exp_n;
    int got;
    bit done;
    exp_n = (k < model_q.size()) ? k : model_q.size();
    got = 0;
    done = 0;
    @(negedge clk);
    rd_req   = 1'b1;
    rd_count = KW'(k);
    @(negedge clk);
    rd_req = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (poke && i == 1) begin rd_req = 1'b1; rd_count = KW'(15); end
      if (poke && i == 2) rd_req = 1'b0;
      if (out_valid) begin
        if (model_q.size() > 0) begin
          logic [DW-1:0] e;
          e = model_q.pop_front();
          chk(out_data == e, {tag, " R6 data order"}, int'(out_data), int'(e));
        end
        got++;
      end
      if (rd_done) begin
        chk(int'(rd_done_count) == exp_n, {tag, " R5 done count"}, int'(rd_done_count), exp_n);
        chk(got == exp_n, {tag, " R5 beats returned"}, got, exp_n);
        done = 1;
        break;
      end
      @(negedge clk);
    end
    rd_req = 1'b0;
    chk(done, {tag, " R5 read completes"}, int'(done), 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    chk(rd_done == 1'b0, "R10 rd_done after reset", int'(rd_done), 0);
    chk(notify == 1'b0, "R10 notify after reset", int'(notify), 0);
    check_counts("R10 reset");
    do_read(5, 0, "R10 empty read");
    do_read(0, 0, "R5 zero request");

    // flag combinations without break: R2 separate and multi-flag counting
    for (int c = 0; c < 8; c++) send(DW'(8'h40 + c), 4'(c));
    end_burst();
    check_counts("R2 after combos");
    // break only: R3
    send(8'h48, 4'b1000);
    end_burst();
    check_counts("R3 break only");
    // break with other flags, drives counters into saturation: R7
    for (int c = 9; c < 16; c++) send(DW'(8'h40 + c), 4'(c));
    end_burst();
    check_counts("R7 saturated");
    send(8'h55, 4'b0111);
    end_burst();
    check_counts("R7 held at max");
    clear_counts();
    // only the clean byte of the sweep is stored: R1
    do_read(4, 0, "R1 flagged bytes dropped");

    // overfill: R4
    for (int i = 0; i < DEPTH + 3; i++) send(DW'(8'h80 + i), 4'd0);
    end_burst();
    do_read(3, 0, "R4 partial");
    do_read(15, 0, "R4 capacity drain");

    // fill-level sweep crossing the wrap many times: R5 R6 R11
    for (int n = 0; n <= DEPTH + 1; n++) begin
      for (int i = 0; i < n; i++) send(DW'(n * 16 + i), (i % 3 == 1) ? 4'b0010 : 4'd0);
      if (n > 0) end_burst();
      do_read((n * 5) % 16, (n == 6), (n == 6) ? "R11 busy request" : "R5 sweep");
      do_read(15, 0, "R6 drain");
    end
    check_counts("R2 sweep parity");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule